// File: doc/BRIEF.md
# Data EEPROM Access Controller

This block gives a small processor byte access to an on-chip data store through a handful of registers on a simple synchronous register bus. Software loads a location into the address register, optionally loads the data register, and then drives a trigger bit in the control register. A write operation runs for a fixed number of clocks and then commits the byte. A read operation runs for a shorter fixed number of clocks and then loads the stored byte into the data register.

Each operation has its own enable bit and its own trigger bit. A trigger is honoured only if its enable was already 1 before the bus write that sets the trigger. The hardware clears a trigger bit when its operation ends, so software polls the trigger bit to learn that the operation has finished. Only one operation runs at a time, and a read and a write can never be started together.

Top module: `eeprom_access_ctrl`

## Requirements
- R1: After reset, every register reads 0 and every byte of the store holds 0.
- R2: Register offsets are: 0 for the address register (6 bits, bits 7:6 read 0), 1 for the data register (8 bits, read/write), and 2 for the control register. Offset 3 reads 0. Control bits 7:4 always read 0.
- R3: In the control register, bit 3 is the write enable, bit 2 the write trigger, bit 1 the read enable and bit 0 the read trigger. Software can set and clear both enable bits freely.
- R4: Setting the write trigger starts a write only if the write enable was already 1 before that bus write. If the enable was 0, the trigger bit stays 0 and no byte is written, even when the same bus write also sets the enable.
- R5: Setting the read trigger starts a read only if the read enable was already 1 before that bus write. If it was not, the trigger bit stays 0 and the data register is not changed.
- R6: A control write that sets both trigger bits starts neither operation, and both trigger bits read 0 afterwards.
- R7: A write reads back its trigger as 1 for exactly WR_CYCLES clocks (default 16) after the triggering bus write, and as 0 after that. The byte committed is the data register value, stored at the address register value, as both stood when the write started.
- R8: A read reads back its trigger as 1 for exactly RD_CYCLES clocks (default 4). When it ends, the data register holds the byte stored at the address captured when the read started.
- R9: While either operation is running, trigger writes are ignored: neither trigger can be set or cleared by software. Changes to the address or data register during a write do not alter the byte committed by that write.
- R10: Once an enable bit has been cleared, later triggers of its operation are ignored. A running operation still completes.
- R11: If a read finishes in the same clock as a bus write to the data register, the byte loaded by the read wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |

## Verification
Two functions can fall in the same clock: the completion of a read, which loads the data register, and a software write to that same register. The bench counts the clocks from the read trigger and places a data-register bus write exactly on the completing edge. It then expects the stored byte, not the software value. In the same way it places trigger and clear attempts inside a running write, and checks that the trigger bit, and the byte committed by that write, are unaffected.

// File: rtl/eectl_pkg.sv
package eectl_pkg;
    localparam int DATA_W = 8;
    localparam int BUS_AW = 2;

    localparam logic [BUS_AW-1:0] OFF_ADDR = 2'd0;
    localparam logic [BUS_AW-1:0] OFF_DATA = 2'd1;
    localparam logic [BUS_AW-1:0] OFF_CTRL = 2'd2;

    localparam int BIT_WEN   = 3;
    localparam int BIT_WTRIG = 2;
    localparam int BIT_REN   = 1;
    localparam int BIT_RTRIG = 0;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2
    } op_state_e;
endpackage

// File: rtl/eectl_array.sv
module eectl_array #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [AW-1:0] commit_addr,
    input  logic [DW-1:0] commit_data,
    input  logic [AW-1:0] fetch_addr,
    output logic [DW-1:0] fetch_data
);
    logic [DW-1:0] cell_q [DEPTH];
    logic [DW-1:0] cell_d [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            cell_d[i] = cell_q[i];
        end
        if (commit) begin
            cell_d[commit_addr] = commit_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= cell_d[i];
            end
        end
    end

    assign fetch_data = cell_q[fetch_addr];
endmodule

// File: rtl/eectl_seq.sv
module eectl_seq
    import eectl_pkg::*;
#(
    parameter int WR_CYCLES = 16,
    parameter int RD_CYCLES = 4,
    parameter int AW        = 6,
    parameter int DW        = 8,
    localparam int MAXC     = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES,
    localparam int CW       = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic          busy,
    output logic          wr_done,
    output logic          rd_done,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data
);
    typedef struct packed {
        op_state_e     st;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } seq_t;

    seq_t seq_q, seq_d;
    logic last;

    always_comb begin
        seq_d   = seq_q;
        last    = (seq_q.cnt == '0);
        wr_done = (seq_q.st == OP_WRITE) && last;
        rd_done = (seq_q.st == OP_READ) && last;
        case (seq_q.st)
            OP_IDLE: begin
                if (start_wr) begin
                    seq_d.st   = OP_WRITE;
                    seq_d.cnt  = CW'(WR_CYCLES - 1);
                    seq_d.addr = addr_in;
                    seq_d.data = data_in;
                end else if (start_rd) begin
                    seq_d.st   = OP_READ;
                    seq_d.cnt  = CW'(RD_CYCLES - 1);
                    seq_d.addr = addr_in;
                end
            end
            default: begin
                if (last) begin
                    seq_d.st = OP_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: OP_IDLE, cnt: '0, addr: '0, data: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy    = (seq_q.st != OP_IDLE);
    assign op_addr = seq_q.addr;
    assign op_data = seq_q.data;

    // R6: the two starts are never requested together
    p_single_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_wr && start_rd));

    // R9: no start is accepted while an operation runs
    p_no_start_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(start_wr || start_rd));

    // R7: a finished write returns to idle
    p_wr_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> !busy);

    // R8: a finished read returns to idle
    p_rd_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> !busy);

    // R9: captured operands stay fixed while busy
    p_hold_operands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(op_addr) && $stable(op_data)));
endmodule

// File: rtl/eeprom_access_ctrl.sv
module eeprom_access_ctrl
    import eectl_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int WR_CYCLES = 16,
    parameter int RD_CYCLES = 4,
    localparam int AW       = $clog2(DEPTH),
    localparam int DW       = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic          wen;
        logic          wtrig;
        logic          ren;
        logic          rtrig;
    } regs_t;

    regs_t r_q, r_d;
    logic start_wr, start_rd;
    logic busy, wr_done, rd_done;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data, fetch_data;

    always_comb begin
        r_d      = r_q;
        start_wr = 1'b0;
        start_rd = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                OFF_ADDR: r_d.addr = bus_wdata[AW-1:0];
                OFF_DATA: r_d.data = bus_wdata;
                OFF_CTRL: begin
                    r_d.wen = bus_wdata[BIT_WEN];
                    r_d.ren = bus_wdata[BIT_REN];
                    if (!busy) begin
                        start_wr = bus_wdata[BIT_WTRIG] && r_q.wen && !bus_wdata[BIT_RTRIG];
                        start_rd = bus_wdata[BIT_RTRIG] && r_q.ren && !bus_wdata[BIT_WTRIG];
                        r_d.wtrig = start_wr;
                        r_d.rtrig = start_rd;
                    end
                end
                default: ;
            endcase
        end
        if (rd_done) begin
            r_d.data  = fetch_data;
            r_d.rtrig = 1'b0;
        end
        if (wr_done) begin
            r_d.wtrig = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (bus_addr)
            OFF_ADDR: bus_rdata = DW'(r_q.addr);
            OFF_DATA: bus_rdata = r_q.data;
            OFF_CTRL: bus_rdata = DW'({r_q.wen, r_q.wtrig, r_q.ren, r_q.rtrig});
            default:  bus_rdata = '0;
        endcase
    end

    eectl_seq #(
        .WR_CYCLES(WR_CYCLES),
        .RD_CYCLES(RD_CYCLES),
        .AW(AW),
        .DW(DW)
    ) u_seq (
        .clk(clk),
        .rst_n(rst_n),
        .start_wr(start_wr),
        .start_rd(start_rd),
        .addr_in(r_q.addr),
        .data_in(r_q.data),
        .busy(busy),
        .wr_done(wr_done),
        .rd_done(rd_done),
        .op_addr(op_addr),
        .op_data(op_data)
    );

    eectl_array #(
        .DEPTH(DEPTH),
        .DW(DW)
    ) u_array (
        .clk(clk),
        .rst_n(rst_n),
        .commit(wr_done),
        .commit_addr(op_addr),
        .commit_data(op_data),
        .fetch_addr(op_addr),
        .fetch_data(fetch_data)
    );

    // R4: the write trigger rises only when the enable was already set
    p_wtrig_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wtrig) |-> $past(r_q.wen));

    // R5: the read trigger rises only when the enable was already set
    p_rtrig_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rtrig) |-> $past(r_q.ren));

    // R6: the two trigger bits are never 1 together
    p_trig_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.wtrig && r_q.rtrig));

    // R7: the write trigger falls only when a write completes
    p_wtrig_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.wtrig) |-> $past(wr_done));

    // R8: the read trigger falls only when a read completes
    p_rtrig_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.rtrig) |-> $past(rd_done));

    // R9: a set trigger bit means an operation is in flight
    p_trig_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.wtrig || r_q.rtrig) |-> busy);
endmodule

// File: tb/eeprom_access_ctrl_tb.sv
module eeprom_access_ctrl_tb;
    localparam int WRC = 16;
    localparam int RDC = 4;
    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] model [DEPTH];

    always #2 clk = ~clk;

    eeprom_access_ctrl #(.DEPTH(DEPTH), .WR_CYCLES(WRC), .RD_CYCLES(RDC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string req);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    function automatic logic [7:0] ctrl_val(input bit wen, input bit wt, input bit ren, input bit rt);
        return {4'b0, wen, wt, ren, rt};
    endfunction

    task automatic do_write(input logic [5:0] a, input logic [7:0] d);
        bus_wr(2'd0, {2'b0, a});
        bus_wr(2'd1, d);
        bus_wr(2'd2, ctrl_val(1, 0, 0, 0));
        bus_wr(2'd2, ctrl_val(1, 1, 0, 0));
        rd_chk(2'd2, ctrl_val(1, 1, 0, 0), "R7 write trigger set");
        repeat (WRC) @(negedge clk);
        rd_chk(2'd2, ctrl_val(1, 0, 0, 0), "R7 write trigger cleared");
        model[a] = d;
    endtask

    task automatic do_read(input logic [5:0] a, input string req);
        bus_wr(2'd0, {2'b0, a});
        bus_wr(2'd2, ctrl_val(0, 0, 1, 0));
        bus_wr(2'd2, ctrl_val(0, 0, 1, 1));
        repeat (RDC) @(negedge clk);
        rd_chk(2'd2, ctrl_val(0, 0, 1, 0), "R8 read trigger cleared");
        rd_chk(2'd1, model[a], req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] seed_dummy;
        seed_dummy = 8'($urandom(32'h5EED_1234));
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(2'd0, 8'h00, "R1 address reset");
        rd_chk(2'd1, 8'h00, "R1 data reset");
        rd_chk(2'd2, 8'h00, "R1 control reset");
        do_read(6'd17, "R1 store reset");

        // R2 map and unimplemented bits
        bus_wr(2'd0, 8'hFF);
        rd_chk(2'd0, 8'h3F, "R2 address width");
        bus_wr(2'd1, 8'hA5);
        rd_chk(2'd1, 8'hA5, "R2 data register");
        rd_chk(2'd3, 8'h00, "R2 offset 3");
        bus_wr(2'd2, 8'hF0);
        rd_chk(2'd2, 8'h00, "R2 control upper bits");

        // R3 enables are plain read/write
        bus_wr(2'd2, ctrl_val(1, 0, 1, 0));
        rd_chk(2'd2, 8'h0A, "R3 both enables set");
        bus_wr(2'd2, 8'h00);
        rd_chk(2'd2, 8'h00, "R3 enables cleared");

        // R4 enable and trigger in one write: nothing starts
        bus_wr(2'd0, 8'h05);
        bus_wr(2'd1, 8'h77);
        bus_wr(2'd2, ctrl_val(1, 1, 0, 0));
        rd_chk(2'd2, 8'h08, "R4 same-write enable ignored");
        repeat (WRC + 2) @(negedge clk);
        do_read(6'd5, "R4 no byte written");

        // R5 read trigger without enable
        bus_wr(2'd1, 8'h3C);
        bus_wr(2'd2, 8'h00);
        bus_wr(2'd2, ctrl_val(0, 0, 0, 1));
        rd_chk(2'd2, 8'h00, "R5 read trigger ignored");
        repeat (RDC + 2) @(negedge clk);
        rd_chk(2'd1, 8'h3C, "R5 data unchanged");

        // R6 both triggers together
        bus_wr(2'd2, ctrl_val(1, 0, 1, 0));
        bus_wr(2'd2, 8'h0F);
        rd_chk(2'd2, 8'h0A, "R6 neither starts");
        repeat (WRC + 2) @(negedge clk);
        rd_chk(2'd1, 8'h3C, "R6 data unchanged");

        // R7 exact write duration
        bus_wr(2'd0, 8'h09);
        bus_wr(2'd1, 8'hC3);
        bus_wr(2'd2, ctrl_val(1, 1, 0, 0));
        repeat (WRC - 1) @(negedge clk);
        rd_chk(2'd2, ctrl_val(1, 1, 0, 0), "R7 trigger still set on last cycle");
        @(negedge clk);
        rd_chk(2'd2, ctrl_val(1, 0, 0, 0), "R7 trigger cleared at end");
        model[9] = 8'hC3;
        do_read(6'd9, "R7 byte committed");

        // R8 exact read duration
        bus_wr(2'd2, ctrl_val(0, 0, 1, 0));
        bus_wr(2'd2, ctrl_val(0, 0, 1, 1));
        repeat (RDC - 1) @(negedge clk);
        rd_chk(2'd2, ctrl_val(0, 0, 1, 1), "R8 trigger still set on last cycle");
        @(negedge clk);
        rd_chk(2'd2, ctrl_val(0, 0, 1, 0), "R8 trigger cleared at end");
        rd_chk(2'd1, 8'hC3, "R8 data loaded");

        // R9 triggers and operand changes during a write
        bus_wr(2'd0, 8'h12);
        bus_wr(2'd1, 8'h5A);
        bus_wr(2'd2, ctrl_val(1, 0, 1, 0));
        bus_wr(2'd2, ctrl_val(1, 1, 1, 0));
        bus_wr(2'd2, ctrl_val(1, 0, 1, 1));
        rd_chk(2'd2, ctrl_val(1, 1, 1, 0), "R9 read trigger ignored while busy");
        bus_wr(2'd2, ctrl_val(1, 0, 1, 0));
        rd_chk(2'd2, ctrl_val(1, 1, 1, 0), "R9 trigger not cleared by software");
        bus_wr(2'd0, 8'h13);
        bus_wr(2'd1, 8'hEE);
        repeat (WRC) @(negedge clk);
        rd_chk(2'd2, ctrl_val(1, 0, 1, 0), "R9 write finished");
        model[18] = 8'h5A;
        do_read(6'd18, "R9 captured byte committed");
        do_read(6'd19, "R9 later address untouched");

        // R10 cleared enable blocks later writes; running write completes
        bus_wr(2'd0, 8'h20);
        bus_wr(2'd1, 8'h99);
        bus_wr(2'd2, ctrl_val(1, 0, 0, 0));
        bus_wr(2'd2, ctrl_val(1, 1, 0, 0));
        bus_wr(2'd2, 8'h00);
        repeat (WRC) @(negedge clk);
        rd_chk(2'd2, 8'h00, "R10 running write completed");
        model[32] = 8'h99;
        bus_wr(2'd0, 8'h21);
        bus_wr(2'd2, ctrl_val(0, 1, 0, 0));
        rd_chk(2'd2, 8'h00, "R10 write blocked");
        repeat (WRC + 2) @(negedge clk);
        do_read(6'd32, "R10 completed byte present");
        do_read(6'd33, "R10 blocked byte absent");

        // R11 read completion versus software data write on the same edge
        bus_wr(2'd0, 8'h20);
        bus_wr(2'd2, ctrl_val(0, 0, 1, 0));
        bus_wr(2'd2, ctrl_val(0, 0, 1, 1));
        repeat (RDC - 1) @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h44; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rd_chk(2'd1, 8'h99, "R11 read load wins");

        // Random mix against the model
        for (int n = 0; n < 150; n++) begin
            logic [5:0] a;
            logic [7:0] d;
            int op;
            op = int'($urandom % 4);
            a = 6'($urandom % DEPTH);
            d = 8'($urandom % 256);
            case (op)
                0: do_write(a, d);
                1: do_read(a, "R8 random read");
                2: begin
                    bus_wr(2'd0, {2'b0, a});
                    bus_wr(2'd1, d);
                    bus_wr(2'd2, 8'h00);
                    bus_wr(2'd2, ctrl_val(0, 1, 0, 0));
                    rd_chk(2'd2, 8'h00, "R4 random disabled write");
                    repeat (WRC) @(negedge clk);
                end
                default: begin
                    bus_wr(2'd1, d);
                    bus_wr(2'd2, 8'h00);
                    bus_wr(2'd2, ctrl_val(0, 0, 0, 1));
                    repeat (RDC + 1) @(negedge clk);
                    rd_chk(2'd1, d, "R5 random disabled read");
                end
            endcase
        end

        // Full sweep of the store
        for (int i = 0; i < DEPTH; i++) begin
            do_read(6'(i), "R7 final store sweep");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule